// File: doc/BRIEF.md
# Selectable-Feedback Shift Register with Output Latch

This block is an 8-stage serial shift register with a separate 8-bit output register. Every control is synchronous to one clock. A step enable moves each stage one place along the chain, from stage a (bit 0) toward stage h (bit 7). The value that enters stage a comes from a feedback network, and a one-bit mode input picks the network.

With the mode input at 0 (twisted-ring mode), stage a takes the inverse of stage h. From an all-zero start this walks through 16 states: ones fill in from a up to h, and then zeros fill in the same way. With the mode input at 1 (pseudo-random mode), stage a takes the XNOR of stage a and stage g. This gives a 7-bit maximal-length sequence over stages a..g. Stage h is not part of that sequence and only repeats the previous value of stage g.

An active-low wipe input clears the chain. A capture strobe copies the chain into the output register. The output pins change only on a capture strobe or on reset, so a controller can step or wipe the chain several times and then show the result in one update.

Top module: `fbsr_latch`

## Requirements
- R1: While `rst` is high at a clock edge, both the chain and `dout` become 8'h00 on that edge.
- R2: With `fb_mode`=0, each step loads stage a (bit 0) with the inverse of stage h (bit 7) and moves bit i to bit i+1. From zero, the chain after k steps reads (1<<k)-1 for k≤8 and (8'hFF<<(k-8)) for 8<k≤16, so it is 8'h00 again after 16 steps.
- R3: With `fb_mode`=1, stage a receives XNOR(bit 0, bit 6). Reading bits 0..6 with weights 64,32,...,1, the states after 0..16 steps from zero are 0,64,32,80,40,84,42,85,106,53,26,77,102,51,25,12,70.
- R4: With `fb_mode`=1, the 7-bit value from zero is nonzero after 1 to 126 steps and is zero again after exactly 127 steps.
- R5: With `fb_mode`=1, after each step bit 7 equals the value bit 6 held before that step.
- R6: A cycle with `wipe_n` low sets all chain bits to 0 and leaves `dout` unchanged.
- R7: `dout` keeps its value on every edge where `capture` is low, whatever `step` and `wipe_n` do.
- R8: When `wipe_n` is low and `step` is high in the same cycle, the chain ends up all zeros.
- R9: When `capture` and `step` are both high in the same cycle, `dout` receives the chain contents from before the step.
- R10: With `step` low and `wipe_n` high, the chain keeps its value.
- R11: Changing `fb_mode` leaves the chain contents unchanged. With `fb_mode`=1, a chain whose bits 0..6 are all ones stays all ones (8'hFF) on every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fb_mode | input | 1 | 0: inverted-tail feedback, 1: two-tap XNOR feedback |
| step | input | 1 | Shift the chain one place this cycle |
| wipe_n | input | 1 | Active-low synchronous clear of the chain |
| capture | input | 1 | Copy the chain into the output register this cycle |
| dout | output | 8 | Output register, bit 0 = stage a, bit 7 = stage h |

## Verification
The chain can only be seen through a capture, so a wrong feedback bit or a wrong tap appears one capture after the step that went wrong. In pseudo-random mode, an error that repeats from there on puts the sequence off the expected table within one or two steps. A wrong stage h path shows when bit 7 of a captured word differs from bit 6 of the word captured the cycle before. Priority mistakes between the controls show in the single capture that follows the conflicting cycle: a wipe that loses to a step leaves nonzero bits, and a capture that takes post-shift data shows the next sequence value instead of the current one.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int unsigned FSR_W = 8;

    typedef enum logic {
        FB_TWIST = 1'b0,
        FB_XNOR  = 1'b1
    } fb_mode_e;

    typedef struct packed {
        logic step;
        logic wipe;
        logic capture;
    } fsr_ctl_t;

    function automatic logic feed_bit(
        input fb_mode_e m,
        input logic     tail,
        input logic     tap_lo,
        input logic     tap_hi
    );
        logic r;
        if (m == FB_TWIST) r = ~tail;
        else               r = ~(tap_lo ^ tap_hi);
        return r;
    endfunction

endpackage

// File: rtl/fsr_feedback.sv
module fsr_feedback
    import fsr_pkg::*;
#(
    parameter int unsigned W      = FSR_W,
    parameter int unsigned TAP_LO = 0,
    parameter int unsigned TAP_HI = 6
) (
    input  fb_mode_e       mode,
    input  logic [W-1:0]   st,
    output logic           ser
);
    localparam int unsigned LAST = W - 1;

    always_comb begin
        ser = feed_bit(mode, st[LAST], st[TAP_LO], st[TAP_HI]);
    end
endmodule

// File: rtl/fsr_chain.sv
module fsr_chain #(
    parameter int unsigned W = fsr_pkg::FSR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         wipe,
    input  logic         ser,
    output logic [W-1:0] st
);
    logic [W-1:0] src;

    assign src = {st[W-2:0], ser};

    for (genvar i = 0; i < W; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst || wipe) st[i] <= 1'b0;
            else if (step)   st[i] <= src[i];
        end
    end

    // R8: wipe has priority over step
    a_r8_wipe_wins: assert property (@(posedge clk) disable iff (rst)
        wipe |=> (st == '0));

    // R10: no step, no wipe, no change
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !wipe) |=> $stable(st));
endmodule

// File: rtl/fsr_outreg.sv
module fsr_outreg #(
    parameter int unsigned W = fsr_pkg::FSR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [W-1:0] st,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (capture) q <= st;
    end

    // R7: output only moves on a capture
    a_r7_out_hold: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(q));

    // R9: capture takes the chain as it stood before this edge
    a_r9_pre_shift: assert property (@(posedge clk) disable iff (rst)
        capture |=> (q == $past(st)));
endmodule

// File: rtl/fbsr_latch.sv
module fbsr_latch
    import fsr_pkg::*;
#(
    parameter int unsigned W      = FSR_W,
    parameter int unsigned TAP_LO = 0,
    parameter int unsigned TAP_HI = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fb_mode,
    input  logic         step,
    input  logic         wipe_n,
    input  logic         capture,
    output logic [W-1:0] dout
);
    localparam int unsigned LAST = W - 1;

    fsr_ctl_t     ctl;
    fb_mode_e     mode;
    logic [W-1:0] chain;
    logic         ser;

    assign ctl  = '{step: step, wipe: ~wipe_n, capture: capture};
    assign mode = fb_mode_e'(fb_mode);

    fsr_feedback #(.W(W), .TAP_LO(TAP_LO), .TAP_HI(TAP_HI)) u_fb (
        .mode (mode),
        .st   (chain),
        .ser  (ser)
    );

    fsr_chain #(.W(W)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .step (ctl.step),
        .wipe (ctl.wipe),
        .ser  (ser),
        .st   (chain)
    );

    fsr_outreg #(.W(W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .capture (ctl.capture),
        .st      (chain),
        .q       (dout)
    );

    // R1: reset clears both registers
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (chain == '0 && dout == '0));

    // R2: twisted-ring feedback enters stage a
    a_r2_twist_feed: assert property (@(posedge clk) disable iff (rst)
        (ctl.step && !ctl.wipe && mode == FB_TWIST) |=> (chain[0] == !$past(chain[LAST])));

    // R5: stage h echoes the previous stage g in XNOR mode
    a_r5_h_echo: assert property (@(posedge clk) disable iff (rst)
        (ctl.step && !ctl.wipe && mode == FB_XNOR) |=> (chain[LAST] == $past(chain[TAP_HI])));

    // R11: all-ones lockup in XNOR mode
    a_r11_lockup: assert property (@(posedge clk) disable iff (rst)
        (ctl.step && !ctl.wipe && mode == FB_XNOR && chain[TAP_HI:0] == '1) |=> (chain[TAP_HI:0] == '1));
endmodule

// File: tb/sim_fbsr_latch.sv
module sim_fbsr_latch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fb_mode = 1'b0;
    logic       step = 1'b0;
    logic       wipe_n = 1'b1;
    logic       capture = 1'b0;
    logic [7:0] dout;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fbsr_latch u0 (
        .clk     (clk),
        .rst     (rst),
        .fb_mode (fb_mode),
        .step    (step),
        .wipe_n  (wipe_n),
        .capture (capture),
        .dout    (dout)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock cycle with the given controls, results visible on return
    task automatic cyc(input logic s, input logic wn, input logic c);
        @(negedge clk);
        step = s; wipe_n = wn; capture = c;
        @(posedge clk);
        #1;
        step = 1'b0; wipe_n = 1'b1; capture = 1'b0;
    endtask

    function automatic int weigh(input logic [7:0] v);
        int r = 0;
        for (int i = 0; i < 7; i++) r = r * 2 + int'(v[i]);
        return r;
    endfunction

    task automatic t_reset();
        chk("R1 dout after reset", dout, 8'h00);
        cyc(0, 1, 1);
        chk("R1 chain after reset", dout, 8'h00);
    endtask

    task automatic t_twist();
        logic [7:0] e;
        fb_mode = 1'b0;
        cyc(0, 0, 0);
        for (int k = 1; k <= 16; k++) begin
            cyc(1, 1, 0);
            cyc(0, 1, 1);
            e = (k <= 8) ? 8'((1 << k) - 1) : 8'(8'hFF << (k - 8));
            chk($sformatf("R2 twist step %0d", k), dout, e);
        end
    endtask

    task automatic t_xnor_table();
        int tbl [17] = '{0, 64, 32, 80, 40, 84, 42, 85, 106, 53, 26, 77, 102, 51, 25, 12, 70};
        fb_mode = 1'b1;
        cyc(0, 0, 0);
        for (int i = 0; i < 17; i++) begin
            cyc(0, 1, 1);
            chk($sformatf("R3 xnor value %0d", i), 8'(weigh(dout)), 8'(tbl[i]));
            cyc(1, 1, 0);
        end
    endtask

    task automatic t_period();
        logic [7:0] prev;
        int early_zero = 0;
        int echo_bad = 0;
        fb_mode = 1'b1;
        cyc(0, 0, 0);
        cyc(1, 1, 1);
        prev = dout;
        chk("R4 start at zero", dout, 8'h00);
        for (int i = 1; i <= 127; i++) begin
            cyc(1, 1, 1);
            if (i < 127 && dout[6:0] == 7'd0) early_zero++;
            if (dout[7] !== prev[6]) echo_bad++;
            prev = dout;
        end
        chk("R4 zero after 127 steps", {1'b0, dout[6:0]}, 8'h00);
        chk("R4 no early zero", 8'(early_zero), 8'h00);
        chk("R5 h echoes previous g", 8'(echo_bad), 8'h00);
    endtask

    task automatic t_wipe_keeps_out();
        fb_mode = 1'b1;
        cyc(0, 0, 0);
        repeat (3) cyc(1, 1, 0);
        cyc(0, 1, 1);
        chk("R6 preload 80", 8'(weigh(dout)), 8'd80);
        cyc(0, 0, 0);
        chk("R6 wipe leaves dout", 8'(weigh(dout)), 8'd80);
        cyc(0, 1, 1);
        chk("R6 chain wiped", dout, 8'h00);
    endtask

    task automatic t_no_capture();
        logic [7:0] held;
        fb_mode = 1'b1;
        cyc(1, 1, 1);
        held = dout;
        repeat (5) cyc(1, 1, 0);
        chk("R7 dout held over steps", dout, held);
        cyc(0, 0, 0);
        chk("R7 dout held over wipe", dout, held);
    endtask

    task automatic t_wipe_wins();
        fb_mode = 1'b0;
        cyc(0, 0, 0);
        repeat (3) cyc(1, 1, 0);
        cyc(1, 0, 0);
        cyc(0, 1, 1);
        chk("R8 wipe beats step", dout, 8'h00);
    endtask

    task automatic t_pre_shift();
        fb_mode = 1'b0;
        cyc(0, 0, 0);
        repeat (2) cyc(1, 1, 0);
        cyc(1, 1, 1);
        chk("R9 capture pre-shift", dout, 8'h03);
        cyc(0, 1, 1);
        chk("R9 post-shift state", dout, 8'h07);
    endtask

    task automatic t_idle();
        fb_mode = 1'b0;
        repeat (4) cyc(0, 1, 0);
        cyc(0, 1, 1);
        chk("R10 chain holds when idle", dout, 8'h07);
    endtask

    task automatic t_lockup();
        fb_mode = 1'b0;
        cyc(0, 0, 0);
        repeat (8) cyc(1, 1, 0);
        fb_mode = 1'b1;
        cyc(0, 1, 1);
        chk("R11 mode switch keeps chain", dout, 8'hFF);
        repeat (5) cyc(1, 1, 0);
        cyc(0, 1, 1);
        chk("R11 all-ones lockup", dout, 8'hFF);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_twist();
        t_xnor_table();
        t_period();
        t_wipe_keeps_out();
        t_no_capture();
        t_wipe_wins();
        t_pre_shift();
        t_idle();
        t_lockup();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                #200000;
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule